// File: doc/BRIEF.md
# T1 Superframe Timing Generator

This block produces the transmit-side timing of a 1.544 Mbit/s T1 line. It runs on the line bit clock and counts the 193 bit periods of each frame and the frame number within a superframe. The superframe is 12 frames long in the D4 format and 24 frames long in the ESF format, chosen by a mode input. Bit 0 of every frame is the framing bit, which the block inserts. Bits 1 to 192 pass straight through from a serial payload input.

In D4 mode the framing bit comes from two fixed six-bit patterns, one for odd frames and one for even frames. In ESF mode the framing slot is shared by three sources: the frame-alignment pattern in every fourth frame, a CRC bit supplied from outside in frames 2, 6, 10 and so on, and a 4 kHz data-link stream in the odd frames. For the data link the block emits a strobe clock and captures the serial data-link input on it. An active-low alignment input forces a superframe restart. An 8 kHz frame clock and a one-bit superframe-start pulse mark the frame and superframe boundaries.

Top module: `t1_sf_timer`

## Requirements
- R1: `bit_no` counts 0,1,...,192 and wraps to 0, advancing by one on every clock edge after reset.
- R2: `frame_no` advances on the edge where `bit_no` goes from 192 to 0, and holds at every other edge. It counts from 1 up to the limit (12 when `esf_mode`=0, 24 when `esf_mode`=1) and then returns to 1. When the count is already at or above the limit, the next boundary returns it to 1.
- R3: When `bit_no` is not 0, `line_bit` equals `payload_bit` in the same cycle.
- R4: When a high-to-low transition of `sf_align_n` is seen at a clock edge, the first frame boundary at or after that edge starts frame 1. Holding the input low counts as one transition only.
- R5: With `esf_mode`=0, `line_bit` at bit 0 of frames 1 to 12 is 1,0,0,0,1,1,0,1,1,1,0,0. This is odd frames 1,0,1,0,1,0 interleaved with even frames 0,0,1,1,1,0.
- R6: With `esf_mode`=1, `line_bit` at bit 0 of frames 4, 8, 12, 16, 20 and 24 is 0,0,1,0,1,1.
- R7: With `esf_mode`=1, `line_bit` at bit 0 of frames 2, 6, 10, 14, 18 and 22 equals `crc_bit` in that cycle.
- R8: With `esf_mode`=1, `dl_clk` is high for exactly the cycle where `bit_no`=192 and the next frame is odd. `dl_bit` is captured at the edge that ends that cycle and appears on `line_bit` at bit 0 of that odd frame. With `esf_mode`=0, `dl_clk` stays low and `dl_bit` has no effect on `line_bit`.
- R9: `frame_clk` is high while `bit_no` is 0 to 96 and low while it is 97 to 192.
- R10: `sf_start` is high exactly when `bit_no`=0 and `frame_no`=1.
- R11: During reset, `bit_no`=0 and `frame_no`=1, and the captured data-link bit is 0. So in ESF mode `line_bit` reads 0 while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.544 MHz line bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| esf_mode | input | 1 | 1 = 24-frame ESF superframe, 0 = 12-frame D4 superframe |
| sf_align_n | input | 1 | Active-low superframe realignment request |
| payload_bit | input | 1 | Serial payload for bits 1 to 192 |
| crc_bit | input | 1 | CRC bit inserted in ESF CRC frames |
| dl_bit | input | 1 | Serial data-link input, captured on `dl_clk` |
| line_bit | output | 1 | Serial transmit bit stream |
| dl_clk | output | 1 | 4 kHz data-link strobe clock (ESF only) |
| frame_clk | output | 1 | 8 kHz frame clock, rising at bit 0 |
| sf_start | output | 1 | One-bit pulse at bit 0 of frame 1 |
| bit_no | output | 8 | Current bit position in the frame |
| frame_no | output | 5 | Current frame number in the superframe |

## Verification
Results arrive at different times. `bit_no`, `frame_no`, `sf_start` and `frame_clk` change at the rising edge, so they reflect the new position in the cycle that follows. `line_bit` follows `payload_bit` and `crc_bit` within the same cycle. A data-link bit driven during the `dl_clk` cycle shows up on `line_bit` in the very next cycle, and an alignment edge takes effect at the first boundary at or after the edge that samples it. The bench drives all inputs just after the falling edge and compares 1 ns later against its own position model. It then advances that model at the following rising edge using the inputs it had just driven, so every check falls in the cycle where the output is due.

// File: rtl/t1sf_pkg.sv
package t1sf_pkg;

  localparam int FRAME_W = 5;

  typedef enum logic [1:0] {
    SLOT_ALIGN = 2'd0,
    SLOT_CRC   = 2'd1,
    SLOT_LINK  = 2'd2
  } esf_slot_e;

  // D4: odd frames walk 1,0,1,0,1,0; even frames walk 0,0,1,1,1,0
  function automatic logic d4_fbit(input logic [FRAME_W-1:0] f);
    logic [FRAME_W-1:0] k;
    if (f[0]) begin
      k = (f - FRAME_W'(1)) >> 1;
      return ~k[0];
    end
    k = (f >> 1) - FRAME_W'(1);
    return (k >= FRAME_W'(2)) && (k <= FRAME_W'(4));
  endfunction

  // ESF alignment pattern in frames 4k, k=1..6: 0,0,1,0,1,1
  function automatic logic esf_align_bit(input logic [FRAME_W-1:0] f);
    logic [FRAME_W-1:0] k;
    k = (f >> 2) - FRAME_W'(1);
    return (k == FRAME_W'(2)) || (k == FRAME_W'(4)) || (k == FRAME_W'(5));
  endfunction

  function automatic esf_slot_e esf_slot(input logic [FRAME_W-1:0] f);
    if (f[0]) return SLOT_LINK;
    if (f[1]) return SLOT_CRC;
    return SLOT_ALIGN;
  endfunction

endpackage

// File: rtl/t1sf_bit_ctr.sv
module t1sf_bit_ctr #(
  parameter int BITS = 193,
  localparam int BW  = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [BW-1:0] bit_cnt,
  output logic          frame_end
);

  localparam logic [BW-1:0] LAST = BW'(BITS - 1);

  assign frame_end = (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bit_cnt <= '0;
    else if (frame_end) bit_cnt <= '0;
    else                bit_cnt <= bit_cnt + BW'(1);
  end

  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> bit_cnt == $past(bit_cnt) + BW'(1)); // R1
  AST_BIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> bit_cnt == '0); // R1

endmodule

// File: rtl/t1sf_frame_ctr.sv
module t1sf_frame_ctr #(
  parameter int D4_N  = 12,
  parameter int ESF_N = 24,
  parameter int FW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          esf_mode,
  input  logic          align_n,
  input  logic          frame_end,
  output logic [FW-1:0] frame_cnt,
  output logic          next_is_odd
);

  logic          align_q;
  logic          pend;
  logic          align_fall;
  logic          align_req;
  logic [FW-1:0] limit;
  logic [FW-1:0] next_frame;

  assign align_fall  = align_q & ~align_n;
  assign align_req   = pend | align_fall;
  assign limit       = esf_mode ? FW'(ESF_N) : FW'(D4_N);
  assign next_frame  = (align_req || frame_cnt >= limit) ? FW'(1)
                                                        : frame_cnt + FW'(1);
  assign next_is_odd = next_frame[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_q   <= 1'b1;
      pend      <= 1'b0;
      frame_cnt <= FW'(1);
    end else begin
      align_q <= align_n;
      if (frame_end) begin
        frame_cnt <= next_frame;
        pend      <= 1'b0;
      end else begin
        pend      <= align_req;
      end
    end
  end

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(frame_cnt)); // R2
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !align_req && frame_cnt < limit
      |=> frame_cnt == $past(frame_cnt) + FW'(1)); // R2
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt != '0 && frame_cnt <= FW'(ESF_N)); // R2
  AST_ALIGN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && align_req |=> frame_cnt == FW'(1)); // R4

endmodule

// File: rtl/t1sf_dl_port.sv
module t1sf_dl_port (
  input  logic clk,
  input  logic rst_n,
  input  logic esf_mode,
  input  logic frame_end,
  input  logic next_is_odd,
  input  logic dl_in,
  output logic dl_clk,
  output logic dl_hold
);

  assign dl_clk = esf_mode & frame_end & next_is_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dl_hold <= 1'b0;
    else if (dl_clk) dl_hold <= dl_in;
  end

  AST_DL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    dl_clk |=> dl_hold == $past(dl_in)); // R8
  AST_DL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_clk |=> $stable(dl_hold)); // R8

endmodule

// File: rtl/t1_sf_timer.sv
module t1_sf_timer
  import t1sf_pkg::*;
#(
  parameter int BITS_PER_FRAME = 193,
  parameter int D4_FRAMES      = 12,
  parameter int ESF_FRAMES     = 24,
  localparam int BW            = $clog2(BITS_PER_FRAME),
  localparam int HALF          = (BITS_PER_FRAME + 1) / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               esf_mode,
  input  logic               sf_align_n,
  input  logic               payload_bit,
  input  logic               crc_bit,
  input  logic               dl_bit,
  output logic               line_bit,
  output logic               dl_clk,
  output logic               frame_clk,
  output logic               sf_start,
  output logic [BW-1:0]      bit_no,
  output logic [FRAME_W-1:0] frame_no
);

  logic       frame_end;
  logic       next_is_odd;
  logic       dl_hold;
  logic       fbit;
  logic       at_fbit;
  esf_slot_e  slot;

  t1sf_bit_ctr #(.BITS(BITS_PER_FRAME)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_cnt   (bit_no),
    .frame_end (frame_end)
  );

  t1sf_frame_ctr #(.D4_N(D4_FRAMES), .ESF_N(ESF_FRAMES), .FW(FRAME_W)) u_frames (
    .clk         (clk),
    .rst_n       (rst_n),
    .esf_mode    (esf_mode),
    .align_n     (sf_align_n),
    .frame_end   (frame_end),
    .frame_cnt   (frame_no),
    .next_is_odd (next_is_odd)
  );

  t1sf_dl_port u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .esf_mode    (esf_mode),
    .frame_end   (frame_end),
    .next_is_odd (next_is_odd),
    .dl_in       (dl_bit),
    .dl_clk      (dl_clk),
    .dl_hold     (dl_hold)
  );

  assign slot    = esf_slot(frame_no);
  assign at_fbit = (bit_no == '0);

  always_comb begin
    if (!esf_mode) begin
      fbit = d4_fbit(frame_no);
    end else begin
      unique case (slot)
        SLOT_ALIGN: fbit = esf_align_bit(frame_no);
        SLOT_CRC:   fbit = crc_bit;
        default:    fbit = dl_hold;
      endcase
    end
  end

  assign line_bit  = at_fbit ? fbit : payload_bit;
  assign frame_clk = (bit_no < BW'(HALF));
  assign sf_start  = at_fbit && (frame_no == FRAME_W'(1));

  AST_SF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |=> !sf_start); // R10
  AST_FCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_clk) |-> bit_no == '0); // R9
  AST_SF_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |-> $past(frame_end) || $past(!rst_n)); // R10

endmodule

// File: tb/t1_sf_timer_tb_top.sv
module t1_sf_timer_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, esf_mode, sf_align_n, payload_bit, crc_bit, dl_bit;
  logic line_bit, dl_clk, frame_clk, sf_start;
  logic [7:0] bit_no;
  logic [4:0] frame_no;

  t1_sf_timer dut_i (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .sf_align_n(sf_align_n),
    .payload_bit(payload_bit), .crc_bit(crc_bit), .dl_bit(dl_bit),
    .line_bit(line_bit), .dl_clk(dl_clk), .frame_clk(frame_clk),
    .sf_start(sf_start), .bit_no(bit_no), .frame_no(frame_no)
  );

  // frames 12..1 of the D4 superframe, and ESF alignment bits for k=6..1
  localparam logic [12:1] D4_SEQ  = 12'b001110110001;
  localparam logic [6:1]  ESF_SEQ = 6'b110100;

  int n_chk = 0, n_err = 0;
  int m_bit, m_frame;
  logic m_pend, m_sfq, m_dl;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got=%0d exp=%0d (model bit %0d frame %0d)",
               tag, got, exp, m_bit, m_frame);
    end
  endtask

  function automatic int next_frame(input logic req);
    int lim = esf_mode ? 24 : 12;
    if (req || m_frame >= lim) return 1;
    return m_frame + 1;
  endfunction

  function automatic logic exp_fbit();
    if (!esf_mode) return D4_SEQ[m_frame];
    if (m_frame % 4 == 0) return ESF_SEQ[m_frame / 4];
    if (m_frame % 4 == 2) return crc_bit;
    return m_dl;
  endfunction

  // one bit period: drive after negedge, check, then follow the rising edge
  task automatic step(input logic al);
    logic req;
    int nf;
    string t;
    sf_align_n  = al;
    payload_bit = lf[0];
    crc_bit     = lf[3];
    dl_bit      = lf[7];
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    #1;
    req = m_pend | (m_sfq & ~al);
    nf  = next_frame(req);
    chk("R1 bit_no", int'(bit_no), m_bit);
    chk("R2 frame_no", int'(frame_no), m_frame);
    chk("R10 sf_start", int'(sf_start), int'(m_bit == 0 && m_frame == 1));
    chk("R9 frame_clk", int'(frame_clk), int'(m_bit <= 96));
    chk("R8 dl_clk", int'(dl_clk), int'(esf_mode && m_bit == 192 && nf % 2 == 1));
    if (m_bit != 0) chk("R3 payload", int'(line_bit), int'(payload_bit));
    else begin
      if (!esf_mode)            t = "R5 d4 fbit";
      else if (m_frame % 4 == 0) t = "R6 esf align";
      else if (m_frame % 4 == 2) t = "R7 esf crc";
      else                      t = "R8 esf link";
      chk(t, int'(line_bit), int'(exp_fbit()));
    end
    @(posedge clk);
    if (m_bit == 192) begin
      if (esf_mode && nf % 2 == 1) m_dl = dl_bit;
      m_frame = nf;
      m_bit   = 0;
      m_pend  = 1'b0;
    end else begin
      m_bit++;
      m_pend = req;
    end
    m_sfq = al;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; esf_mode = 1'b1; sf_align_n = 1'b1;
    payload_bit = 1'b0; crc_bit = 1'b1; dl_bit = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 bit_no in reset", int'(bit_no), 0);
    chk("R11 frame_no in reset", int'(frame_no), 1);
    chk("R11 link bit cleared", int'(line_bit), 0);
    chk("R10 sf_start in reset", int'(sf_start), 1);
    esf_mode = 1'b0;
    #1;
    chk("R5 d4 frame1 in reset", int'(line_bit), 1);
    @(negedge clk);
    rst_n = 1'b1;
    m_bit = 0; m_frame = 1; m_pend = 1'b0; m_sfq = 1'b1; m_dl = 1'b0;
  endtask

  task automatic t_d4_run();
    esf_mode = 1'b0;
    repeat (2 * 12 * 193 + 20) step(1'b1);
  endtask

  task automatic t_esf_run();
    esf_mode = 1'b1;
    repeat (2 * 24 * 193 + 20) step(1'b1);
  endtask

  task automatic t_align();
    esf_mode = 1'b1;
    repeat (300) step(1'b1);
    repeat (3) step(1'b0);              // R4 mid-frame pulse
    repeat (400) step(1'b1);
    while (m_bit != 192) step(1'b1);
    step(1'b0);                         // R4 pulse on the boundary cycle
    chk("R4 boundary align", int'(frame_no), 1);
    repeat (300) step(1'b1);
    repeat (600) step(1'b0);            // R4 held low: one restart only
    repeat (500) step(1'b1);
    esf_mode = 1'b0;
    repeat (250) step(1'b1);
    repeat (2) step(1'b0);
    repeat (600) step(1'b1);
  endtask

  task automatic t_mode_switch();
    esf_mode = 1'b1;
    while (m_frame != 20) step(1'b1);
    esf_mode = 1'b0;                    // R2 count above D4 limit returns to 1
    repeat (2 * 12 * 193) step(1'b1);
    esf_mode = 1'b1;
    repeat (24 * 193) step(1'b1);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R1 got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_d4_run();
    t_esf_run();
    t_align();
    t_mode_switch();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule